// File: doc/BRIEF.md
# Single-Wire Link Rate Probe

This block sits on the host end of a single-wire, open-drain debug link. Its job is to find out how fast the target end of the link runs. When it is told to start, it pulls the wire low for a long, fixed time, which the target reads as a rate-discovery request. It then drives the wire high for one clock to speed up the rising edge, and lets go of the wire. The target answers with a low pulse that is 128 of its own link cycles long. The block counts how many host clocks that answering low lasts.

The block turns the low count into host clocks per link cycle. It does this by dividing by 128 with rounding to the nearest value. The answer only needs to be accurate to a few percent, because later traffic on the link tolerates errors of several percent.

Two conditions end the run with an error flag and no result. The first is a target that never answers within a time-out. The second is an answer whose low lasts longer than a set limit. The pin input is assumed to be synchronized to the host clock already. Sending normal commands and data over the link is handled elsewhere.

Top module: `synclink_rate_probe`

## Requirements
- R1: Out of reset, the wire is released (`pin_oe_o` low), `busy_o`, `done_o` and `err_o` are low, and both result fields read zero.
- R2: A `start_i` sampled high while idle starts a run. From the next cycle on, the block drives the wire low (`pin_oe_o`=1, `pin_out_o`=0) for exactly REQ_LOW_CLKS clocks, and `busy_o` is high.
- R3: The driven low is followed by exactly one clock of driving the wire high (`pin_oe_o`=1, `pin_out_o`=1). After that the wire is released, and it stays released until the next run.
- R4: After release, counting begins with the first low sample of `pin_in_i` that follows a high sample. It ends with the first high sample after that. `low_count_o` reports the number of low samples.
- R5: `cyc_per_bit_o` equals (`low_count_o` + 64) shifted right by 7. This is the low count divided by 128, rounded to nearest.
- R6: `done_o` is a pulse one clock long. It comes in the clock after the sample that ends the run, with `busy_o` already low. The result fields and `err_o` change only in that clock, and they hold until the next run ends.
- R7: If no countable low begins within TIMEOUT_CLKS clocks after release, the run ends with `done_o`, `err_o`=1, and both result fields at zero.
- R8: A low of up to MAX_LOW_CLKS samples gives a result. A low that reaches MAX_LOW_CLKS+1 samples ends the run at once with `err_o`=1 and both result fields at zero.
- R9: `start_i` is ignored while a run is in progress. The request low is neither restarted nor lengthened, and only one `done_o` pulse follows.
- R10: Starting a new run clears `err_o` in the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a rate measurement when idle |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-clock pulse at the end of a run |
| err_o | output | 1 | Last run ended by time-out or over-long low |
| low_count_o | output | CNT_W | Host clocks the target's answer was low |
| cyc_per_bit_o | output | CNT_W-6 | Rounded host clocks per target link cycle |
| pin_oe_o | output | 1 | Drive enable for the link wire |
| pin_out_o | output | 1 | Value driven when enabled |
| pin_in_i | input | 1 | Synchronized level of the link wire |

## Verification
The bench builds the block with a request low of 40 clocks, a time-out of 100 clocks, a low limit of 1000 samples and a 12-bit counter. These short windows let it check the exact request length and both sides of the time-out edge (99 and 100 high samples) in a short run. They also let it check both sides of the low limit (1000 and 1001 samples). The 12-bit counter still leaves room for the rounding edges at 63/64 and 703/704 samples.

// File: rtl/srp_pkg.sv
package srp_pkg;

    // The target's answer is 2**LINK_CYC_LOG2 of its link cycles long.
    localparam int unsigned LINK_CYC_LOG2 = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_KICK,
        PH_LISTEN,
        PH_MEASURE,
        PH_FINISH
    } phase_e;

endpackage

// File: rtl/srp_seq.sv
// Run sequencer: request low, speedup high, listen, measure, finish.
module srp_seq
    import srp_pkg::*;
#(
    parameter int unsigned REQ_LOW_CLKS = 2048,
    parameter int unsigned TIMEOUT_CLKS = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic pin_in_i,
    input  logic at_max_i,
    output logic accept_o,
    output logic meas_load_o,
    output logic meas_inc_o,
    output logic end_ok_o,
    output logic end_err_o,
    output logic pin_oe_o,
    output logic pin_out_o,
    output logic busy_o,
    output logic done_o
);

    localparam int unsigned REQ_W = $clog2(REQ_LOW_CLKS + 1);
    localparam int unsigned TMO_W = $clog2(TIMEOUT_CLKS + 1);

    typedef struct packed {
        phase_e           ph;
        logic [REQ_W-1:0] req_cnt;
        logic [TMO_W-1:0] tmo_cnt;
        logic             heard_high;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        accept_o    = 1'b0;
        meas_load_o = 1'b0;
        meas_inc_o  = 1'b0;
        end_ok_o    = 1'b0;
        end_err_o   = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.ph      = PH_REQ;
                    seq_d.req_cnt = '0;
                    accept_o      = 1'b1;
                end
            end
            PH_REQ: begin
                if (seq_q.req_cnt == REQ_W'(REQ_LOW_CLKS - 1)) begin
                    seq_d.ph = PH_KICK;
                end else begin
                    seq_d.req_cnt = seq_q.req_cnt + 1'b1;
                end
            end
            PH_KICK: begin
                seq_d.ph         = PH_LISTEN;
                seq_d.tmo_cnt    = '0;
                seq_d.heard_high = 1'b0;
            end
            PH_LISTEN: begin
                if (seq_q.heard_high && !pin_in_i) begin
                    seq_d.ph    = PH_MEASURE;
                    meas_load_o = 1'b1;
                end else if (seq_q.tmo_cnt == TMO_W'(TIMEOUT_CLKS - 1)) begin
                    seq_d.ph  = PH_FINISH;
                    end_err_o = 1'b1;
                end else begin
                    seq_d.tmo_cnt = seq_q.tmo_cnt + 1'b1;
                    if (pin_in_i) begin
                        seq_d.heard_high = 1'b1;
                    end
                end
            end
            PH_MEASURE: begin
                if (pin_in_i) begin
                    seq_d.ph = PH_FINISH;
                    end_ok_o = 1'b1;
                end else if (at_max_i) begin
                    seq_d.ph  = PH_FINISH;
                    end_err_o = 1'b1;
                end else begin
                    meas_inc_o = 1'b1;
                end
            end
            PH_FINISH: begin
                seq_d.ph = PH_IDLE;
            end
            default: begin
                seq_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{ph: PH_IDLE, req_cnt: '0, tmo_cnt: '0, heard_high: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pin_oe_o  = (seq_q.ph == PH_REQ) || (seq_q.ph == PH_KICK);
    assign pin_out_o = (seq_q.ph == PH_KICK);
    assign busy_o    = (seq_q.ph == PH_REQ) || (seq_q.ph == PH_KICK) ||
                       (seq_q.ph == PH_LISTEN) || (seq_q.ph == PH_MEASURE);
    assign done_o    = (seq_q.ph == PH_FINISH);

endmodule

// File: rtl/srp_meter.sv
// Low-time counter with an upper limit flag.
module srp_meter #(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned MAX_LOW_CLKS = 60000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_max_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } meter_t;

    meter_t mtr_d, mtr_q;

    always_comb begin
        mtr_d = mtr_q;
        if (load_i) begin
            mtr_d.cnt = CNT_W'(1);
        end else if (inc_i) begin
            mtr_d.cnt = mtr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mtr_q <= '{cnt: '0};
        end else begin
            mtr_q <= mtr_d;
        end
    end

    assign cnt_o    = mtr_q.cnt;
    assign at_max_o = (mtr_q.cnt == CNT_W'(MAX_LOW_CLKS));

endmodule

// File: rtl/srp_scale.sv
// Divide by the answer length in link cycles, rounding to nearest.
module srp_scale
    import srp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0]               cnt_i,
    output logic [CNT_W-LINK_CYC_LOG2:0]   cpb_o
);

    localparam int unsigned HALF = 1 << (LINK_CYC_LOG2 - 1);

    logic [CNT_W:0] biased;

    assign biased = {1'b0, cnt_i} + (CNT_W + 1)'(HALF);
    assign cpb_o  = biased[CNT_W:LINK_CYC_LOG2];

endmodule

// File: rtl/synclink_rate_probe.sv
// Host-side link rate probe: request, listen, measure, scale.
module synclink_rate_probe
    import srp_pkg::*;
#(
    parameter int unsigned REQ_LOW_CLKS = 2048,
    parameter int unsigned TIMEOUT_CLKS = 4096,
    parameter int unsigned MAX_LOW_CLKS = 60000,
    parameter int unsigned CNT_W        = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         err_o,
    output logic [CNT_W-1:0]             low_count_o,
    output logic [CNT_W-LINK_CYC_LOG2:0] cyc_per_bit_o,
    output logic                         pin_oe_o,
    output logic                         pin_out_o,
    input  logic                         pin_in_i
);

    localparam int unsigned CPB_W = CNT_W - LINK_CYC_LOG2 + 1;

    logic             accept, meas_load, meas_inc, end_ok, end_err, at_max;
    logic [CNT_W-1:0] cnt;
    logic [CPB_W-1:0] cpb;

    srp_seq #(
        .REQ_LOW_CLKS (REQ_LOW_CLKS),
        .TIMEOUT_CLKS (TIMEOUT_CLKS)
    ) seq_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .pin_in_i    (pin_in_i),
        .at_max_i    (at_max),
        .accept_o    (accept),
        .meas_load_o (meas_load),
        .meas_inc_o  (meas_inc),
        .end_ok_o    (end_ok),
        .end_err_o   (end_err),
        .pin_oe_o    (pin_oe_o),
        .pin_out_o   (pin_out_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    srp_meter #(
        .CNT_W        (CNT_W),
        .MAX_LOW_CLKS (MAX_LOW_CLKS)
    ) meter_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (meas_load),
        .inc_i    (meas_inc),
        .cnt_o    (cnt),
        .at_max_o (at_max)
    );

    srp_scale #(
        .CNT_W (CNT_W)
    ) scale_i (
        .cnt_i (cnt),
        .cpb_o (cpb)
    );

    typedef struct packed {
        logic [CNT_W-1:0] low;
        logic [CPB_W-1:0] cpb;
        logic             err;
    } result_t;

    result_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (accept) begin
            res_d.err = 1'b0;
        end
        if (end_ok) begin
            res_d.low = cnt;
            res_d.cpb = cpb;
            res_d.err = 1'b0;
        end else if (end_err) begin
            res_d.low = '0;
            res_d.cpb = '0;
            res_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '{low: '0, cpb: '0, err: 1'b0};
        end else begin
            res_q <= res_d;
        end
    end

    assign low_count_o   = res_q.low;
    assign cyc_per_bit_o = res_q.cpb;
    assign err_o         = res_q.err;

endmodule

// File: rtl/srp_checker.sv
// Port-level properties of the rate probe.
module srp_checker #(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned MAX_LOW_CLKS = 60000
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [CNT_W-1:0] low_count_o,
    input logic [CNT_W-7:0] cyc_per_bit_o,
    input logic             pin_oe_o,
    input logic             pin_out_o
);

    logic [CNT_W:0] rounded_sum;
    assign rounded_sum = {1'b0, low_count_o} + (CNT_W + 1)'(64);

    a_r1_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !pin_oe_o);

    a_r3_release_after_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_oe_o && pin_out_o) |=> !pin_oe_o);

    a_r3_kick_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_oe_o && !pin_out_o) |=> pin_oe_o);

    a_r5_rounding: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o) |-> (cyc_per_bit_o == rounded_sum[CNT_W:7]));

    a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r6_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && !pin_oe_o));

    a_r6_result_moves_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(low_count_o) |-> done_o);

    a_r7_err_rises_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> done_o);

    a_r8_bounded_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o) |-> (low_count_o != '0 && low_count_o <= CNT_W'(MAX_LOW_CLKS)));

    a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind synclink_rate_probe srp_checker #(
    .CNT_W        (CNT_W),
    .MAX_LOW_CLKS (MAX_LOW_CLKS)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .low_count_o   (low_count_o),
    .cyc_per_bit_o (cyc_per_bit_o),
    .pin_oe_o      (pin_oe_o),
    .pin_out_o     (pin_out_o)
);

// File: tb/synclink_rate_probe_tb_top.sv
module synclink_rate_probe_tb_top;

    localparam int REQ = 40;
    localparam int TMO = 100;
    localparam int MAXL = 1000;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tgt = 1'b1;
    logic busy, done, err, oe, drv, line;
    logic [CW-1:0] low;
    logic [CW-7:0] cpb;

    int n_chk = 0;
    int n_bad = 0;
    int done_pulses = 0;
    int cap_err = 0;
    int cap_low = 0;
    int cap_cpb = 0;

    always #2 clk = ~clk;

    assign line = oe ? drv : tgt;

    synclink_rate_probe #(
        .REQ_LOW_CLKS (REQ),
        .TIMEOUT_CLKS (TMO),
        .MAX_LOW_CLKS (MAXL),
        .CNT_W        (CW)
    ) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .busy_o        (busy),
        .done_o        (done),
        .err_o         (err),
        .low_count_o   (low),
        .cyc_per_bit_o (cpb),
        .pin_oe_o      (oe),
        .pin_out_o     (drv),
        .pin_in_i      (line)
    );

    always @(negedge clk) begin
        if (done) begin
            done_pulses++;
            cap_err = int'(err);
            cap_low = int'(low);
            cap_cpb = int'(cpb);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rnd(input int n);
        return (n + 64) / 128;
    endfunction

    // One run: gap high samples after release, then n low samples.
    task automatic do_run(input int gap, input int n, input bit poke, input bit ok_end);
        int lowcnt;
        done_pulses = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(err == 1'b0, "R10 err cleared on start", int'(err), 0);
        lowcnt = 0;
        while (oe && !drv && lowcnt < 5000) begin
            start = (poke && (lowcnt == 5 || lowcnt == 20)) ? 1'b1 : 1'b0;
            lowcnt++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(lowcnt == REQ, poke ? "R9 request not restarted" : "R2 request low length",
            lowcnt, REQ);
        chk(oe && drv, "R3 speedup high", int'({oe, drv}), 3);
        @(negedge clk);
        chk(!oe, "R3 released after speedup", int'(oe), 0);
        repeat (gap) @(negedge clk);
        if (n > 0) begin
            tgt = 1'b0;
            repeat (n) @(negedge clk);
            tgt = 1'b1;
            if (ok_end) begin
                @(negedge clk);
                chk(done && !busy, "R6 done in clock after ending high", int'({done, busy}), 2);
                @(negedge clk);
                chk(!done, "R6 done lasts one clock", int'(done), 0);
            end
        end
        for (int i = 0; i < TMO + 20 && done_pulses == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done_pulses == 1, "R6/R9 single done pulse", done_pulses, 1);
        chk(!oe, "R3 wire stays released", int'(oe), 0);
    endtask

    task automatic t_reset;
        chk(!oe && !busy && !done && !err, "R1 idle outputs", int'({oe, busy, done, err}), 0);
        chk(low == 0 && cpb == 0, "R1 result zero", int'(low), 0);
    endtask

    task automatic t_ok(input int gap, input int n, input string tag);
        do_run(gap, n, 1'b0, 1'b1);
        chk(cap_err == 0, {tag, " err low"}, cap_err, 0);
        chk(cap_low == n, {"R4 low count ", tag}, cap_low, n);
        chk(cap_cpb == rnd(n), {"R5 rounded rate ", tag}, cap_cpb, rnd(n));
        repeat (5) @(negedge clk);
        chk(int'(low) == n, "R6 result held", int'(low), n);
    endtask

    task automatic t_busy_start;
        do_run(10, 300, 1'b1, 1'b1);
        chk(cap_low == 300 && cap_err == 0, "R9 run unaffected by start", cap_low, 300);
    endtask

    task automatic t_timeout;
        do_run(TMO, 30, 1'b0, 1'b0);
        chk(cap_err == 1, "R7 time-out flags error", cap_err, 1);
        chk(cap_low == 0 && cap_cpb == 0, "R7 result zero on time-out", cap_low, 0);
        chk(err == 1'b1, "R6 err held", int'(err), 1);
    endtask

    task automatic t_overflow;
        do_run(5, MAXL + 1, 1'b0, 1'b0);
        chk(cap_err == 1, "R8 over-long low flags error", cap_err, 1);
        chk(cap_low == 0 && cap_cpb == 0, "R8 result zero on over-long low", cap_low, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ok(16, 256, "basic");
        t_ok(3, 63, "R5 below half");
        t_ok(3, 64, "R5 at half");
        t_ok(7, 703, "R5 703");
        t_ok(7, 704, "R5 704");
        t_busy_start();
        t_timeout();
        t_ok(TMO - 1, 100, "R7 last allowed gap");
        t_ok(5, MAXL, "R8 at limit");
        t_overflow();
        t_ok(1, 128, "R10 after error");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule